// File: doc/BRIEF.md
# Multi-Mode LCD Host Interface

This block is the host-facing front end of a display controller. One pin set carries commands and display data in one of three modes: a full byte per transfer on eight data pins, a byte split into two 4-bit transfers on the low four pins, or one bit per shift-clock on a single pin. A low-active strobe frames every transfer. A second pin acts as the data enable in the parallel modes and as the shift clock in the serial mode. A direction pin chooses between host writes and host reads.

The block brings every pin through a synchronizer into the system clock, finds edges there and assembles complete bytes. Each finished write byte leaves on a byte-wide request port as a one-cycle pulse. Read bytes come from a response input that the rest of the controller keeps loaded. A take pulse tells the controller when it may present the next byte. During reads the block drives the data pins through a per-bit output enable.

Top module: `lcd_host_if`

## Requirements
- R1: With the word-width pin high at mode lock, every shift-clock rise while the strobe is low and the direction is write delivers data pins 7..0 as one byte on `wr_byte`.
- R2: With the word-width pin low and data pin 7 high at mode lock, a byte takes two shift-clock rises on pins 3..0. The first rise carries bits 7..4 and the second carries bits 3..0, and one byte is delivered per pair.
- R3: With the word-width pin and data pin 7 both low at mode lock, data pin 0 is shifted in MSB first. Every eighth rise completes a byte and the count wraps, so back-to-back bytes need no strobe toggle.
- R4: While the strobe is high, shift-clock activity produces no byte, and every output enable stays low.
- R5: Any strobe edge, rising or falling, discards a partly received nibble pair or bit count.
- R6: The mode is decoded from the synchronized word-width pin and data pin 7 on the third clock edge after reset release. It is then held until the next reset, whatever those pins do.
- R7: The data pins are driven only while the synchronized strobe is low and the direction is read. The enable mask is 8'hFF in byte mode, 8'h0F in nibble mode and 8'h01 in serial mode.
- R8: On a strobe fall with the direction read, `rd_byte` is loaded and `rd_take` pulses. Each shift-clock fall moves to the next beat: upper nibble before lower nibble, and bit 7 first on pin 0 in serial mode. After the last beat of a byte, the next `rd_byte` is loaded with another `rd_take` pulse.
- R9: Each pin passes two synchronizing flops. `wr_valid` is high for exactly one cycle, set on the second clock edge after the edge that first samples the completing shift-clock rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hs_word8 | input | 1 | Word-width select, sampled once at mode lock |
| hs_strobe_n | input | 1 | Active-low transfer frame |
| hs_clk | input | 1 | Data enable (parallel) or shift clock (serial) |
| hs_read | input | 1 | Direction: 1 read, 0 write |
| hs_d_in | input | 8 | Data pins as seen by the block; pin 7 is also the nibble/serial select |
| hs_d_out | output | 8 | Read data toward the data pins |
| hs_d_oe | output | 8 | Per-pin output enable |
| wr_valid | output | 1 | One-cycle pulse for each completed write byte |
| wr_byte | output | 8 | Completed write byte |
| rd_byte | input | 8 | Response byte for the next host read |
| rd_take | output | 1 | Pulse when `rd_byte` has been taken |

## Verification
Writes are run in all three modes with patterns that have distinct upper and lower halves. This exposes swapped nibbles or an LSB-first shift. Back-to-back serial bytes show whether the bit counter wraps. A strobe toggle in the middle of a nibble pair or bit run shows whether partial state is dropped. Shift-clock pulses with the strobe high, and word-width changes after lock, check that those pins are ignored. Reads of several bytes per frame check the beat order and the reload of the response byte. A behavioural model compares every output on every clock.

// File: rtl/lcd_hif_pkg.sv
package lcd_hif_pkg;

   typedef enum logic [1:0] {
      HIF_SERIAL = 2'd0,
      HIF_NIBBLE = 2'd1,
      HIF_BYTE   = 2'd2
   } hif_mode_e;

   localparam int HIF_BUS_W = 8;

   // transfers needed for one byte in a given mode
   function automatic int unsigned beats_per_byte(hif_mode_e m, int unsigned w);
      case (m)
         HIF_BYTE:   return 1;
         HIF_NIBBLE: return 2;
         default:    return w;
      endcase
   endfunction

endpackage

// File: rtl/lcd_hif_sync.sv
module lcd_hif_sync #(
   parameter int            W       = 1,
   parameter int            STAGES  = 2,
   parameter logic [W-1:0]  RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("lcd_hif_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/lcd_hif_capture.sv
module lcd_hif_capture import lcd_hif_pkg::*; #(
   parameter int BUS_W = HIF_BUS_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  hif_mode_e        mode,
   input  logic             clear,
   input  logic             step,
   input  logic [BUS_W-1:0] din,
   output logic             valid,
   output logic [BUS_W-1:0] data
);

   localparam int CNT_W = $clog2(BUS_W);
   localparam int HALF  = BUS_W / 2;

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] last;
   logic [BUS_W-1:0] acc, nxt;

   assign last = CNT_W'(beats_per_byte(mode, BUS_W) - 1);

   always_comb begin
      case (mode)
         HIF_BYTE:   nxt = din;
         HIF_NIBBLE: nxt = {acc[HALF-1:0], din[HALF-1:0]};
         default:    nxt = {acc[BUS_W-2:0], din[0]};
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         acc   <= '0;
         valid <= 1'b0;
         data  <= '0;
      end else begin
         valid <= 1'b0;
         if (clear) begin
            cnt <= '0;
         end else if (step) begin
            acc <= nxt;
            if (cnt == last) begin
               cnt   <= '0;
               valid <= 1'b1;
               data  <= nxt;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   assert_cnt_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= last);
   assert_valid_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid);
   assert_clear_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (!valid && cnt == '0));

endmodule

// File: rtl/lcd_hif_readout.sv
module lcd_hif_readout import lcd_hif_pkg::*; #(
   parameter int BUS_W = HIF_BUS_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  hif_mode_e        mode,
   input  logic             clear,
   input  logic             load,
   input  logic             step,
   input  logic [BUS_W-1:0] resp,
   output logic             take,
   output logic [BUS_W-1:0] pin_out
);

   localparam int CNT_W = $clog2(BUS_W);
   localparam int HALF  = BUS_W / 2;

   logic [CNT_W-1:0] beat;
   logic [CNT_W-1:0] last;
   logic [BUS_W-1:0] buf_q;

   assign last = CNT_W'(beats_per_byte(mode, BUS_W) - 1);

   always_comb begin
      pin_out = '0;
      case (mode)
         HIF_BYTE:   pin_out = buf_q;
         HIF_NIBBLE: pin_out[HALF-1:0] = (beat == '0) ? buf_q[BUS_W-1:HALF] : buf_q[HALF-1:0];
         default:    pin_out[0] = buf_q[BUS_W-1-int'(beat)];
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         beat  <= '0;
         buf_q <= '0;
         take  <= 1'b0;
      end else begin
         take <= 1'b0;
         if (load) begin
            buf_q <= resp;
            beat  <= '0;
            take  <= 1'b1;
         end else if (clear) begin
            beat <= '0;
         end else if (step) begin
            if (beat == last) begin
               buf_q <= resp;
               beat  <= '0;
               take  <= 1'b1;
            end else begin
               beat <= beat + 1'b1;
            end
         end
      end
   end

   assert_beat_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      beat <= last);

endmodule

// File: rtl/lcd_host_if.sv
module lcd_host_if import lcd_hif_pkg::*; #(
   parameter int BUS_W       = HIF_BUS_W,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hs_word8,
   input  logic             hs_strobe_n,
   input  logic             hs_clk,
   input  logic             hs_read,
   input  logic [BUS_W-1:0] hs_d_in,
   output logic [BUS_W-1:0] hs_d_out,
   output logic [BUS_W-1:0] hs_d_oe,
   output logic             wr_valid,
   output logic [BUS_W-1:0] wr_byte,
   input  logic [BUS_W-1:0] rd_byte,
   output logic             rd_take
);

   localparam int PIN_W  = BUS_W + 4;
   localparam int LOCK_W = $clog2(SYNC_STAGES + 1);
   localparam int HALF   = BUS_W / 2;
   localparam logic [PIN_W-1:0] PIN_RST = {1'b0, 1'b0, 1'b1, 1'b0, {BUS_W{1'b0}}};

   if (BUS_W < 4 || (BUS_W % 2) != 0) begin : g_bad_width
      $error("lcd_host_if: BUS_W must be even and at least 4");
   end

   // synchronized pin bundle: {word8, read, strobe_n, clk, data}
   logic [PIN_W-1:0] pins_s;
   logic             s_word8, s_read, s_stb, s_en;
   logic [BUS_W-1:0] s_d;

   lcd_hif_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({hs_word8, hs_read, hs_strobe_n, hs_clk, hs_d_in}),
      .q     (pins_s)
   );

   assign {s_word8, s_read, s_stb, s_en, s_d} = pins_s;

   // mode lock after the synchronizer has filled
   logic [LOCK_W-1:0] lock_cnt;
   logic              locked;
   hif_mode_e         mode, mode_pins;

   assign mode_pins = s_word8 ? HIF_BYTE : (s_d[BUS_W-1] ? HIF_NIBBLE : HIF_SERIAL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_cnt <= '0;
         locked   <= 1'b0;
         mode     <= HIF_SERIAL;
      end else if (!locked) begin
         if (lock_cnt == LOCK_W'(SYNC_STAGES)) begin
            locked <= 1'b1;
            mode   <= mode_pins;
         end else begin
            lock_cnt <= lock_cnt + 1'b1;
         end
      end
   end

   // edge detection in the system clock domain
   logic stb_q, en_q;
   logic stb_edge, active, en_rise, en_fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stb_q <= 1'b1;
         en_q  <= 1'b0;
      end else begin
         stb_q <= s_stb;
         en_q  <= s_en;
      end
   end

   assign stb_edge = locked && (s_stb != stb_q);
   assign active   = locked && !s_stb && !stb_q;
   assign en_rise  = active && s_en && !en_q;
   assign en_fall  = active && !s_en && en_q;

   lcd_hif_capture #(.BUS_W(BUS_W)) i_capture (
      .clk   (clk),
      .rst_n (rst_n),
      .mode  (mode),
      .clear (stb_edge),
      .step  (en_rise && !s_read),
      .din   (s_d),
      .valid (wr_valid),
      .data  (wr_byte)
   );

   lcd_hif_readout #(.BUS_W(BUS_W)) i_readout (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (mode),
      .clear   (stb_edge),
      .load    (stb_edge && !s_stb && s_read),
      .step    (en_fall && s_read),
      .resp    (rd_byte),
      .take    (rd_take),
      .pin_out (hs_d_out)
   );

   // per-mode drive mask
   logic [BUS_W-1:0] mask;
   always_comb begin
      case (mode)
         HIF_BYTE:   mask = '1;
         HIF_NIBBLE: mask = {{(BUS_W-HALF){1'b0}}, {HALF{1'b1}}};
         default:    mask = {{(BUS_W-1){1'b0}}, 1'b1};
      endcase
   end

   assign hs_d_oe = (locked && !s_stb && s_read) ? mask : '0;

   assert_mode_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> (locked && $stable(mode)));
   assert_no_write_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(s_stb) |-> !wr_valid);
   assert_take_on_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && $fell(s_stb) && s_read) |=> rd_take);
   assert_oe_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_d_oe != '0) |-> ($countones(hs_d_oe) == $countones(mask)));

endmodule

// File: tb/test_lcd_host_if.sv
`timescale 1ns/1ps
module test_lcd_host_if;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hs_word8 = 1'b1, hs_strobe_n = 1'b1, hs_clk = 1'b0, hs_read = 1'b0;
   logic [7:0] hs_d_in = 8'h00;
   logic [7:0] rd_byte = 8'hA6;
   wire  [7:0] hs_d_out, hs_d_oe, wr_byte;
   wire        wr_valid, rd_take;

   int checks = 0, errors = 0;
   bit done = 0;
   string tag = "R1";
   logic [7:0] exp_q[$];

   always #2.5 clk = ~clk;

   lcd_host_if i_lcd_host_if (
      .clk(clk), .rst_n(rst_n), .hs_word8(hs_word8), .hs_strobe_n(hs_strobe_n),
      .hs_clk(hs_clk), .hs_read(hs_read), .hs_d_in(hs_d_in), .hs_d_out(hs_d_out),
      .hs_d_oe(hs_d_oe), .wr_valid(wr_valid), .wr_byte(wr_byte),
      .rd_byte(rd_byte), .rd_take(rd_take));

   task automatic chk(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference, evaluated on every edge --------
   logic [11:0] h1, h2;          // {word8, read, strobe_n, clk, data}
   bit m_stb_p, m_en_p, m_lock, e_wv, e_take;
   int m_lk, m_mode, wcnt, rbeat; // mode: 2 byte, 1 nibble, 0 serial
   logic [7:0] wacc, e_wd, rbuf;

   always @(posedge clk) begin
      if (!rst_n) begin
         h1 = 12'h200; h2 = 12'h200; m_stb_p = 1; m_en_p = 0; m_lock = 0;
         m_lk = 0; m_mode = 0; wcnt = 0; rbeat = 0; wacc = 0; e_wd = 0;
         rbuf = 0; e_wv = 0; e_take = 0;
      end else begin
         bit sb, ec, rdir, edg, act, rise, fall;
         int nb;
         logic [7:0] dd, v;
         sb = h2[9]; ec = h2[8]; rdir = h2[10]; dd = h2[7:0];
         edg  = m_lock && (sb != m_stb_p);
         act  = m_lock && !sb && !m_stb_p;
         rise = act && ec && !m_en_p;
         fall = act && !ec && m_en_p;
         nb = (m_mode == 2) ? 1 : (m_mode == 1) ? 2 : 8;
         e_wv = 0; e_take = 0;
         if (edg) wcnt = 0;
         else if (rise && !rdir) begin
            if (m_mode == 2) v = dd;
            else if (m_mode == 1) v = {wacc[3:0], dd[3:0]};
            else v = {wacc[6:0], dd[0]};
            wacc = v;
            if (wcnt == nb - 1) begin e_wv = 1; e_wd = v; wcnt = 0; end
            else wcnt++;
         end
         if (edg && !sb && rdir) begin rbuf = rd_byte; rbeat = 0; e_take = 1; end
         else if (edg) rbeat = 0;
         else if (fall && rdir) begin
            if (rbeat == nb - 1) begin rbuf = rd_byte; rbeat = 0; e_take = 1; end
            else rbeat++;
         end
         if (!m_lock) begin
            if (m_lk == 2) begin m_lock = 1; m_mode = h2[11] ? 2 : (dd[7] ? 1 : 0); end
            else m_lk++;
         end
         m_stb_p = sb; m_en_p = ec;
         h2 = h1; h1 = {hs_word8, hs_read, hs_strobe_n, hs_clk, hs_d_in};
      end
   end

   // per-clock comparison and byte scoreboard, away from the active edge
   always @(negedge clk) begin
      logic [7:0] eoe, eout;
      eoe = 8'h00; eout = 8'h00;
      if (rst_n && m_lock && !h2[9] && h2[10])
         eoe = (m_mode == 2) ? 8'hFF : (m_mode == 1) ? 8'h0F : 8'h01;
      if (m_mode == 2) eout = rbuf;
      else if (m_mode == 1) eout = {4'h0, (rbeat == 0) ? rbuf[7:4] : rbuf[3:0]};
      else eout = {7'h0, rbuf[7 - rbeat]};
      chk(wr_valid == e_wv, "R9", "wr_valid vs model", wr_valid, e_wv);
      if (e_wv) chk(wr_byte == e_wd, "R9", "wr_byte vs model", wr_byte, e_wd);
      chk(rd_take == e_take, "R8", "rd_take vs model", rd_take, e_take);
      chk(hs_d_oe == eoe, "R7", "hs_d_oe vs model", hs_d_oe, eoe);
      chk((hs_d_out & eoe) == (eout & eoe), "R8", "hs_d_out vs model", hs_d_out & eoe, eout & eoe);
      if (wr_valid) begin
         if (exp_q.size() == 0) chk(0, "R4", "unexpected write byte", wr_byte, 0);
         else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk(wr_byte == e, tag, "received byte", wr_byte, e);
         end
      end
      if (rd_take) rd_byte <= rd_byte + 8'h35;
   end

   // ---------------- stimulus helpers ----------------
   task automatic tick(int n); repeat (n) @(negedge clk); endtask

   task automatic do_reset(bit w8, bit sel);
      rst_n = 0; hs_word8 = w8; hs_d_in = {sel, 7'h00};
      hs_strobe_n = 1; hs_clk = 0; hs_read = 0;
      tick(2);
      chk(wr_valid == 0 && rd_take == 0 && hs_d_oe == 0, "R6", "outputs idle in reset",
          {wr_valid, rd_take, hs_d_oe}, 0);
      tick(2); rst_n = 1; tick(8);
   endtask

   task automatic strobe(bit v); hs_strobe_n = v; tick(5); endtask

   task automatic beat(logic [7:0] v);
      hs_d_in = v; tick(3); hs_clk = 1; tick(4); hs_clk = 0; tick(4);
   endtask

   task automatic wr_full(logic [7:0] b);  exp_q.push_back(b); beat(b); endtask
   task automatic wr_nib(logic [7:0] b);
      exp_q.push_back(b); beat({4'h8, b[7:4]}); beat({4'h8, b[3:0]});
   endtask
   task automatic wr_ser(logic [7:0] b);
      exp_q.push_back(b);
      for (int i = 7; i >= 0; i--) beat({7'h00, b[i]});
   endtask

   task automatic rd_frame(int mode, int n, string req);
      logic [7:0] e;
      hs_read = 1; tick(3);
      e = rd_byte;
      strobe(0);
      for (int k = 0; k < n; k++) begin
         int nb;
         nb = (mode == 2) ? 1 : (mode == 1) ? 2 : 8;
         for (int b = 0; b < nb; b++) begin
            logic [7:0] want, got;
            if (mode == 2) begin want = e; got = hs_d_out; end
            else if (mode == 1) begin want = {4'h0, (b == 0) ? e[7:4] : e[3:0]}; got = hs_d_out & 8'h0F; end
            else begin want = {7'h0, e[7 - b]}; got = hs_d_out & 8'h01; end
            chk(got == want, req, "read beat on pins", got, want);
            hs_clk = 1; tick(4); hs_clk = 0; tick(5);
         end
         e = e + 8'h35;
      end
      strobe(1); hs_read = 0; tick(4);
   endtask

   task automatic drain(string req);
      tick(6);
      chk(exp_q.size() == 0, req, "bytes still expected", exp_q.size(), 0);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: run did not complete");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   // ---------------- test sequence ----------------
   initial begin
      // byte mode
      do_reset(1, 0);
      tag = "R1";
      strobe(0); wr_full(8'hA5); wr_full(8'h3C); wr_full(8'h00); wr_full(8'hFF); strobe(1);
      drain("R1");
      // R4: shift-clock pulses with strobe high give nothing
      tag = "R4";
      for (int i = 0; i < 3; i++) beat(8'h5A);
      chk(hs_d_oe == 0, "R4", "no drive with strobe high", hs_d_oe, 0);
      drain("R4");
      // R6: word-width pin dropped after lock, mode stays byte-wide
      tag = "R6";
      hs_word8 = 0; tick(4);
      strobe(0); wr_full(8'h81); strobe(1); drain("R6");
      hs_word8 = 1;
      rd_frame(2, 3, "R7");

      // nibble mode
      do_reset(0, 1);
      tag = "R2";
      strobe(0); wr_nib(8'h6E); wr_nib(8'hC3); strobe(1); drain("R2");
      // R5: lone upper nibble dropped by a strobe toggle
      tag = "R5";
      strobe(0); beat(8'h8F); strobe(1); strobe(0); wr_nib(8'h21); strobe(1); drain("R5");
      rd_frame(1, 2, "R8");

      // serial mode
      do_reset(0, 0);
      tag = "R3";
      strobe(0); wr_ser(8'hB2); wr_ser(8'h4D); strobe(1); drain("R3");
      tag = "R5";
      strobe(0); beat(8'h01); beat(8'h01); beat(8'h00); strobe(0);
      strobe(1); strobe(0); wr_ser(8'h96); strobe(1); drain("R5");
      // R6: nibble-select pin raised after lock, still serial
      tag = "R6";
      hs_word8 = 0; hs_d_in = 8'h80; tick(4);
      strobe(0); wr_ser(8'h5A); strobe(1); drain("R6");
      rd_frame(0, 2, "R8");

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule